// File: doc/BRIEF.md
# Comparator Event and Trigger Controller

This block is the digital wrapper around an analog comparator. It receives the single-bit raw comparison result, which is high when the positive input is above the negative input, and passes it through a two-stage synchronizer. It then applies enable and polarity inversion and drives the result to a pin together with a pin output-enable. It watches the synchronized result for the edge that software has selected. When that edge arrives it raises a one-cycle trigger/interrupt pulse and sets a sticky event flag. While the flag is set, every later trigger is blocked until software clears it.

Software reaches the block through a 16-bit control/status word. A write replaces every writable bit at once. The read value is always present on `rd_data_o`. The reference-select bit and the two channel-select bits have no function inside this block. They are only stored and read back for the analog front end.

The edge selection always refers to the raw comparison direction. "Rising" means the positive input has just moved above the negative input, whatever the polarity bit says. With the polarity bit set, that same event appears as a falling edge of the output bit.

Top module: `cmp_evt_ctrl`

## Requirements
- R1: After reset every writable bit reads 0, `rd_data_o` is 16'h0000, and `pin_oe_o`, `pin_val_o`, `evt_flag_o` and `trig_o` are all 0.
- R2: The control word has these fields: bit 15 enable, bit 14 pin enable, bit 13 polarity, bit 9 event flag, bit 8 output (read-only), bits 7:6 edge select, bit 4 reference select, bits 1:0 channel select. Bits 12:10, 5, 3 and 2 always read 0. Every writable bit reads back the value last written to it, except where R9 and R11 say otherwise.
- R3: With enable set, read bit 8 equals the synchronized raw input when polarity is 0, and its inverse when polarity is 1.
- R4: `pin_oe_o` follows bit 14. When bit 14 is 1, `pin_val_o` equals read bit 8. When bit 14 is 0, `pin_val_o` is 0.
- R5: Edge select 2'b00 never produces a trigger or sets the flag.
- R6: Edge select 2'b01 fires on a 0-to-1 change of the synchronized raw input, for either polarity. This is a rising output edge when polarity is 0 and a falling output edge when polarity is 1.
- R7: Edge select 2'b10 fires on a 1-to-0 change of the synchronized raw input, for either polarity.
- R8: Edge select 2'b11 fires on any change of the synchronized raw input.
- R9: A qualifying edge sets the event flag. While the flag is 1, further edges produce no trigger. Without a write, the flag stays 1.
- R10: `trig_o` is a one-cycle pulse that rises in the same cycle as the flag set by that edge.
- R11: If a write that clears the flag lands in the same cycle as a qualifying edge, the edge wins. The flag stays 1 and `trig_o` pulses.
- R12: With enable 0, read bit 8 is 0 and no edge is detected. Re-enabling with the raw input steady raises no event.
- R13: A raw input change becomes visible in bit 8 two clocks after it is applied. The matching trigger follows one clock after that.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cmp_raw_i | input | 1 | Raw comparator result, asynchronous |
| wr_en_i | input | 1 | Control-word write strobe |
| wr_data_i | input | 16 | Control-word write data |
| rd_data_o | output | 16 | Control/status read value |
| pin_val_o | output | 1 | Value for the comparator output pin |
| pin_oe_o | output | 1 | Output enable for that pin |
| evt_flag_o | output | 1 | Sticky event flag |
| trig_o | output | 1 | One-cycle trigger/interrupt pulse |

## Verification
A software write to the control word and a detected edge can land in the same clock. This matters most when the write clears the event flag and the edge is due to set it. The bench counts the synchronizer latency so that a clearing write reaches the register in exactly the cycle the edge is detected. It then expects the flag to stay set with a trigger pulse. Random phases also mix writes with input toggles, and a bench model rules on every such overlap.

// File: rtl/cmp_evt_pkg.sv
package cmp_evt_pkg;
  localparam int unsigned REG_W = 16;

  localparam int unsigned B_EN   = 15;
  localparam int unsigned B_OE   = 14;
  localparam int unsigned B_POL  = 13;
  localparam int unsigned B_FLG  = 9;
  localparam int unsigned B_OUT  = 8;
  localparam int unsigned B_SELH = 7;
  localparam int unsigned B_SELL = 6;
  localparam int unsigned B_REF  = 4;
  localparam int unsigned B_CHH  = 1;
  localparam int unsigned B_CHL  = 0;

  typedef enum logic [1:0] {
    EDGE_OFF  = 2'b00,
    EDGE_RISE = 2'b01,
    EDGE_FALL = 2'b10,
    EDGE_ANY  = 2'b11
  } edge_sel_e;

  typedef struct packed {
    logic      en;
    logic      oe;
    logic      pol;
    edge_sel_e sel;
    logic      ref_sel;
    logic [1:0] chan;
  } ctrl_t;
endpackage

// File: rtl/cmp_evt_sync.sv
module cmp_evt_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic d_i,
  output logic q_o
);
  logic [STAGES-1:0] stg_q;

  generate
    if (STAGES == 1) begin : g_one
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) stg_q <= '0;
        else         stg_q <= d_i;
      end
    end else begin : g_many
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) stg_q <= '0;
        else         stg_q <= {stg_q[STAGES-2:0], d_i};
      end
    end
  endgenerate

  assign q_o = stg_q[STAGES-1];
endmodule

// File: rtl/cmp_evt_edge.sv
module cmp_evt_edge
  import cmp_evt_pkg::*;
(
  input  logic      clk_i,
  input  logic      rst_ni,
  input  logic      en_i,
  input  edge_sel_e sel_i,
  input  logic      raw_i,
  output logic      hit_o
);
  logic prev_q;
  logic rise, fall, match;

  // history always tracks, so re-enable sees no stale edge
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) prev_q <= 1'b0;
    else         prev_q <= raw_i;
  end

  assign rise = raw_i & ~prev_q;
  assign fall = ~raw_i & prev_q;

  always_comb begin
    unique case (sel_i)
      EDGE_RISE: match = rise;
      EDGE_FALL: match = fall;
      EDGE_ANY:  match = rise | fall;
      default:   match = 1'b0;
    endcase
  end

  assign hit_o = en_i & match;
endmodule

// File: rtl/cmp_evt_regs.sv
module cmp_evt_regs
  import cmp_evt_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             wr_en_i,
  input  logic [REG_W-1:0] wr_data_i,
  input  logic             hit_i,
  input  logic             out_i,
  output ctrl_t            ctrl_o,
  output logic             flag_o,
  output logic             trig_o,
  output logic [REG_W-1:0] rd_data_o
);
  ctrl_t ctrl_q;
  logic  flag_q, trig_q;
  logic  clr_wr, fire;

  assign clr_wr = wr_en_i & ~wr_data_i[B_FLG];
  // event beats a same-cycle clearing write
  assign fire   = hit_i & (~flag_q | clr_wr);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ctrl_q <= '0;
      flag_q <= 1'b0;
      trig_q <= 1'b0;
    end else begin
      trig_q <= fire;
      if (wr_en_i) begin
        ctrl_q.en      <= wr_data_i[B_EN];
        ctrl_q.oe      <= wr_data_i[B_OE];
        ctrl_q.pol     <= wr_data_i[B_POL];
        ctrl_q.sel     <= edge_sel_e'(wr_data_i[B_SELH:B_SELL]);
        ctrl_q.ref_sel <= wr_data_i[B_REF];
        ctrl_q.chan    <= wr_data_i[B_CHH:B_CHL];
      end
      if (fire)         flag_q <= 1'b1;
      else if (wr_en_i) flag_q <= wr_data_i[B_FLG];
    end
  end

  always_comb begin
    rd_data_o                = '0;
    rd_data_o[B_EN]          = ctrl_q.en;
    rd_data_o[B_OE]          = ctrl_q.oe;
    rd_data_o[B_POL]         = ctrl_q.pol;
    rd_data_o[B_FLG]         = flag_q;
    rd_data_o[B_OUT]         = out_i;
    rd_data_o[B_SELH:B_SELL] = ctrl_q.sel;
    rd_data_o[B_REF]         = ctrl_q.ref_sel;
    rd_data_o[B_CHH:B_CHL]   = ctrl_q.chan;
  end

  assign ctrl_o = ctrl_q;
  assign flag_o = flag_q;
  assign trig_o = trig_q;
endmodule

// File: rtl/cmp_evt_ctrl.sv
module cmp_evt_ctrl
  import cmp_evt_pkg::*;
#(
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             cmp_raw_i,
  input  logic             wr_en_i,
  input  logic [REG_W-1:0] wr_data_i,
  output logic [REG_W-1:0] rd_data_o,
  output logic             pin_val_o,
  output logic             pin_oe_o,
  output logic             evt_flag_o,
  output logic             trig_o
);
  logic  raw_s, hit, out_bit;
  ctrl_t ctrl;

  cmp_evt_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   (cmp_raw_i),
    .q_o   (raw_s)
  );

  cmp_evt_edge u_edge (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .en_i  (ctrl.en),
    .sel_i (ctrl.sel),
    .raw_i (raw_s),
    .hit_o (hit)
  );

  assign out_bit = ctrl.en & (raw_s ^ ctrl.pol);

  cmp_evt_regs u_regs (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .wr_en_i  (wr_en_i),
    .wr_data_i(wr_data_i),
    .hit_i    (hit),
    .out_i    (out_bit),
    .ctrl_o   (ctrl),
    .flag_o   (evt_flag_o),
    .trig_o   (trig_o),
    .rd_data_o(rd_data_o)
  );

  assign pin_oe_o  = ctrl.oe;
  assign pin_val_o = ctrl.oe & out_bit;
endmodule

// File: rtl/cmp_evt_chk.sv
module cmp_evt_chk (
  input logic        clk_i,
  input logic        rst_ni,
  input logic        wr_en_i,
  input logic [15:0] wr_data_i,
  input logic [15:0] rd_data_o,
  input logic        pin_val_o,
  input logic        pin_oe_o,
  input logic        evt_flag_o,
  input logic        trig_o
);
  AST_UNIMPL_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_data_o[12:10] == 3'b0 && rd_data_o[5] == 1'b0 && rd_data_o[3:2] == 2'b0); // R2
  AST_PIN_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !pin_oe_o |-> !pin_val_o); // R4
  AST_PIN_FOLLOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pin_oe_o |-> pin_val_o == rd_data_o[8]); // R4
  AST_OFF_OUT_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rd_data_o[15] |-> !rd_data_o[8]); // R12
  AST_SEL_OFF_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_data_o[7:6] == 2'b00 |=> !trig_o); // R5
  AST_FLAG_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    evt_flag_o && !wr_en_i |=> evt_flag_o); // R9
  AST_TRIG_GATED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    trig_o |-> $past(!evt_flag_o || (wr_en_i && !wr_data_i[9]))); // R9
  AST_TRIG_WITH_FLAG: assert property (@(posedge clk_i) disable iff (!rst_ni)
    trig_o |-> evt_flag_o); // R10
  AST_FLAG_RISE_TRIG: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(evt_flag_o) && !$past(wr_en_i) |-> trig_o); // R10
endmodule

bind cmp_evt_ctrl cmp_evt_chk u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .wr_en_i   (wr_en_i),
  .wr_data_i (wr_data_i),
  .rd_data_o (rd_data_o),
  .pin_val_o (pin_val_o),
  .pin_oe_o  (pin_oe_o),
  .evt_flag_o(evt_flag_o),
  .trig_o    (trig_o)
);

// File: tb/tb_cmp_evt_ctrl.sv
module tb_cmp_evt_ctrl;
  localparam logic [15:0] EN = 16'h8000, OE = 16'h4000, POL = 16'h2000, FLG = 16'h0200;
  localparam logic [15:0] S_RISE = 16'h0040, S_FALL = 16'h0080, S_ANY = 16'h00C0;
  localparam logic [15:0] WMASK = 16'hE2D3;

  logic clk_i = 1'b0, rst_ni = 1'b0;
  logic cmp_raw_i = 1'b0, wr_en_i = 1'b0;
  logic [15:0] wr_data_i = '0;
  logic [15:0] rd_data_o;
  logic pin_val_o, pin_oe_o, evt_flag_o, trig_o;

  int total = 0, fails = 0;
  bit done = 0;
  string cur_tag = "R1";

  always #4 clk_i = ~clk_i;

  cmp_evt_ctrl dut (.*);

  // bench model
  logic m_s1, m_s2, m_p, m_trig;
  logic [15:0] m_reg;

  function automatic logic m_hit(logic [15:0] r, logic s, logic p, logic we, logic [15:0] wd);
    logic m;
    case (r[7:6])
      2'b01: m = s & ~p;
      2'b10: m = ~s & p;
      2'b11: m = s ^ p;
      default: m = 1'b0;
    endcase
    return r[15] & m & (~r[9] | (we & ~wd[9]));
  endfunction

  function automatic logic m_out();
    return m_reg[15] & (m_s2 ^ m_reg[13]);
  endfunction

  always @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      m_s1 <= 0; m_s2 <= 0; m_p <= 0; m_trig <= 0; m_reg <= '0;
    end else begin
      logic h;
      logic [15:0] nr;
      h = m_hit(m_reg, m_s2, m_p, wr_en_i, wr_data_i);
      nr = wr_en_i ? (wr_data_i & WMASK) : m_reg;
      if (h) nr[9] = 1'b1;
      m_reg <= nr; m_trig <= h;
      m_s1 <= cmp_raw_i; m_s2 <= m_s1; m_p <= m_s2;
    end
  end

  task automatic chk(string tag, string what, logic [15:0] act, logic [15:0] exp);
    total++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
    end
  endtask

  task automatic cmp_all();
    logic o;
    o = m_out();
    chk(cur_tag, "rd_data", rd_data_o, (m_reg & WMASK) | (16'(o) << 8));
    chk(cur_tag, "pin_oe", 16'(pin_oe_o), 16'(m_reg[14]));
    chk(cur_tag, "pin_val", 16'(pin_val_o), 16'(m_reg[14] & o));
    chk(cur_tag, "flag", 16'(evt_flag_o), 16'(m_reg[9]));
    chk(cur_tag, "trig", 16'(trig_o), 16'(m_trig));
  endtask

  task automatic cyc(logic raw, logic we, logic [15:0] wd);
    @(negedge clk_i);
    cmp_all();
    cmp_raw_i = raw; wr_en_i = we; wr_data_i = wd;
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) cyc(cmp_raw_i, 1'b0, '0);
  endtask

  task automatic wr(logic [15:0] d);
    cyc(cmp_raw_i, 1'b1, d);
    cyc(cmp_raw_i, 1'b0, '0);
  endtask

  task automatic toggles(int n);
    for (int i = 0; i < n; i++) begin
      cyc(~cmp_raw_i, 1'b0, '0);
      idle(3);
      if (i % 2 == 1) wr(wr_data_i_cfg);
    end
  endtask

  logic [15:0] wr_data_i_cfg;

  task automatic phase(string tag, logic [15:0] cfg, int n);
    cur_tag = tag;
    wr_data_i_cfg = cfg;
    wr(cfg);
    idle(3);
    toggles(n);
  endtask

  task automatic summary();
    $display("  %0d/%0d checks passed", total - fails, total);
  endtask

  initial begin
    repeat (150000) @(posedge clk_i);
    if (!done) begin
      total++; fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      summary();
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5eed_c0de));
    repeat (3) @(negedge clk_i);
    // R1 reset state
    chk("R1", "rd_data", rd_data_o, 16'h0000);
    chk("R1", "pins", {14'b0, pin_oe_o, pin_val_o}, 16'h0);
    chk("R1", "flag/trig", {14'b0, evt_flag_o, trig_o}, 16'h0);
    rst_ni = 1'b1;
    idle(2);

    // R2 field readback, unimplemented bits
    cur_tag = "R2";
    wr(16'hFFFF & ~FLG & ~EN);
    chk("R2", "readback all-ones", rd_data_o, 16'h60D3);
    wr(16'h0012);
    chk("R2", "readback pattern", rd_data_o, 16'h0012);

    // R13 latency + R10 pulse alignment
    cur_tag = "R13";
    wr(EN | S_RISE);
    idle(3);
    cyc(1'b1, 1'b0, '0);
    @(negedge clk_i);
    chk("R13", "out after 1 clk", 16'(rd_data_o[8]), 16'h0);
    @(negedge clk_i);
    chk("R13", "out after 2 clk", 16'(rd_data_o[8]), 16'h1);
    chk("R10", "no trig yet", 16'(trig_o), 16'h0);
    @(negedge clk_i);
    chk("R10", "trig with flag", {14'b0, trig_o, evt_flag_o}, 16'h3);
    @(negedge clk_i);
    chk("R10", "trig single pulse", {14'b0, trig_o, evt_flag_o}, 16'h1);

    // R9 flag blocks further edges
    cur_tag = "R9";
    cyc(1'b0, 1'b0, '0); idle(3);
    cyc(1'b1, 1'b0, '0); idle(4);
    chk("R9", "blocked trig", 16'(trig_o), 16'h0);
    chk("R9", "flag held", 16'(evt_flag_o), 16'h1);

    // R11 clearing write collides with new edge
    cur_tag = "R11";
    wr(EN | S_ANY | FLG);
    idle(3);
    cyc(1'b0, 1'b0, '0);      // raw falls before edge 1
    cyc(1'b0, 1'b0, '0);      // edge 1
    cyc(1'b0, 1'b1, EN | S_ANY); // clear lands on edge 3 with hit
    @(negedge clk_i);
    chk("R11", "flag kept, trig", {14'b0, trig_o, evt_flag_o}, 16'h3);
    wr_en_i = 1'b0;
    idle(2);

    // R12 disabled then re-enabled
    cur_tag = "R12";
    wr(S_ANY | OE);
    cyc(1'b1, 1'b0, '0); idle(3);
    chk("R12", "out zero when off", 16'(rd_data_o[8]), 16'h0);
    chk("R12", "no flag when off", 16'(evt_flag_o), 16'h0);
    wr(EN | OE | S_ANY);
    idle(4);
    chk("R12", "no event on re-enable", {14'b0, trig_o, evt_flag_o}, 16'h0);

    // mode sweeps with model
    phase("R3", EN | OE | POL, 4);
    phase("R4", EN | POL, 3);
    phase("R5", EN | OE, 4);
    phase("R6", EN | OE | S_RISE, 4);
    phase("R6", EN | OE | POL | S_RISE, 4);
    phase("R7", EN | S_FALL, 4);
    phase("R7", EN | POL | S_FALL, 4);
    phase("R8", EN | OE | S_ANY, 4);

    // random mix of toggles and writes
    cur_tag = "R9";
    for (int i = 0; i < 3000; i++) begin
      logic [15:0] d;
      logic we;
      d = 16'($urandom);
      if ($urandom_range(3) != 0) d[9] = 1'b0;
      if ($urandom_range(3) != 0) d[15] = 1'b1;
      we = ($urandom_range(5) == 0);
      cyc(($urandom_range(3) == 0) ? ~cmp_raw_i : cmp_raw_i, we, d);
    end
    idle(3);

    done = 1;
    summary();
    $finish;
  end
endmodule